// File: doc/BRIEF.md
# Processor Supply Sequencer

This block is a synchronous state machine that puts the supply controls of a processor core in order during power-up and power-down. It watches a flag saying the VID supply rail is above 1 V, a valid flag from the core regulator and a platform power request. From these it drives three outputs in turn: the regulator output enable (`vr_en`), the processor power-good (`pwr_good`) and the active-low processor reset (`cpu_rst_n`). A fourth output, `fault`, latches when the core regulator fails to report valid in time.

Every interval is measured by counters. Their lengths are parameters given in milliseconds, scaled by `CYC_PER_MS`, the number of clock cycles in one millisecond. The one exception is the power-good low time, which is counted in bus-clock ticks. A tick is a one-cycle pulse that is synchronous to `clk`.

The three level inputs are asynchronous. Each passes through its own `SYNC_STAGES`-deep synchronizer before the state machine uses it. The reset window is checked when the design elaborates: `RST_DLY_MS` must lie between 1 and 10.

Top module: `pwr_seq_ctrl`

In the timing rules below:
- "Edge k" counts rising clock edges after the edge that follows an input change.
- `SYNC_STAGES` is 2.
- `N1 = VID_SETTLE_MS*CYC_PER_MS`, `N2 = VCC_TMO_MS*CYC_PER_MS` and `N3 = RST_DLY_MS*CYC_PER_MS`.

## Requirements
- R1: `vr_en` is low whenever the synchronized VID flag is low. When the VID flag drops, `vr_en`, `pwr_good` and `cpu_rst_n` all go low after edge 2.
- R2: With the request high, `vr_en` rises after edge N1+3 counted from the rise of the VID flag. The synchronized flag has then been high for at least N1 cycles.
- R3: If the regulator valid flag rises d edges after `vr_en` rises, and d is at most N2-3, no fault occurs and the sequence continues.
- R4: If valid is not seen in time, then on the N2-th edge after `vr_en` rises, `fault` goes high and `vr_en` goes low. While `fault` is high, `vr_en`, `pwr_good` and `cpu_rst_n` are all low.
- R5: `fault` stays high for as long as the request stays high, whatever the other inputs do. It clears after edge 3 once the request falls.
- R6: `pwr_good` rises on the edge that samples the `PG_LOW_TICKS`-th bus tick high. Ticks are counted from edge 4 onward, where edges are numbered from the rise of the valid flag.
- R7: `cpu_rst_n` rises exactly N3 edges after `pwr_good` rises. This interval always lies within 1 to 10 ms.
- R8: `cpu_rst_n` is low whenever `pwr_good` is low.
- R9: Power-down on removal of the request or loss of the valid flag:
  - `pwr_good` and `cpu_rst_n` drop after edge 3.
  - `vr_en` drops one edge later, after edge 4.
- R10: After reset, and in idle with no request, all four outputs are low.
- R11: If the request is withdrawn while the VID settle interval is still running, `vr_en` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | 1 | One-cycle bus-clock tick, synchronous to clk |
| vid_ok_a | input | 1 | VID rail above 1 V (asynchronous) |
| vcc_ok_a | input | 1 | Core regulator valid (asynchronous) |
| pwr_req_a | input | 1 | Platform power request (asynchronous) |
| vr_en | output | 1 | Core regulator output enable |
| pwr_good | output | 1 | Processor power-good |
| cpu_rst_n | output | 1 | Processor reset, active low |
| fault | output | 1 | Latched regulator timeout fault |

## Verification
The hardest situation to reach from the ports is a valid flag arriving right at the edge of the timeout window. Because of the synchronizer delay, d = N2-3 must still succeed while d = N2-2 must already fault.

The bench uses a scaled configuration, with four cycles per millisecond. It places the arrival of the valid flag at both sides of that boundary, counting edges from the observed rise of `vr_en`.

It also sweeps every tick period from 1 to 4 at every phase, and computes edge by edge where the tenth counted tick falls. The three power-down causes are rotated across these sweeps.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_VID_WAIT,
      ST_VCC_WAIT,
      ST_PG_HOLD,
      ST_RST_HOLD,
      ST_RUN,
      ST_OFF,
      ST_FAULT
   } pseq_state_e;

   localparam int SIG_VID = 0;
   localparam int SIG_VCC = 1;
   localparam int SIG_REQ = 2;
   localparam int SIG_CNT = 3;

endpackage

// File: rtl/pwr_sync.sv
`timescale 1ns/1ps
module pwr_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pwr_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/pwr_tmr.sv
`timescale 1ns/1ps
module pwr_tmr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         en,
   output logic         done
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (load)              cnt_q <= load_val;
      else if (en && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int CYC_PER_MS    = 100000,
   parameter int VID_SETTLE_MS = 1,
   parameter int VCC_TMO_MS    = 50,
   parameter int RST_DLY_MS    = 2,
   parameter int PG_LOW_TICKS  = 10,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_tick,
   input  logic vid_ok_a,
   input  logic vcc_ok_a,
   input  logic pwr_req_a,
   output logic vr_en,
   output logic pwr_good,
   output logic cpu_rst_n,
   output logic fault
);

   localparam int SETTLE_CYC = VID_SETTLE_MS * CYC_PER_MS;
   localparam int TMO_CYC    = VCC_TMO_MS * CYC_PER_MS;
   localparam int RSTD_CYC   = RST_DLY_MS * CYC_PER_MS;
   localparam int MAX_A      = (SETTLE_CYC > TMO_CYC) ? SETTLE_CYC : TMO_CYC;
   localparam int MAX_CYC    = (MAX_A > RSTD_CYC) ? MAX_A : RSTD_CYC;
   localparam int TW         = $clog2(MAX_CYC + 1);
   localparam int BW         = $clog2(PG_LOW_TICKS + 1);

   if (CYC_PER_MS < 1) begin : g_bad_cpm
      $error("pwr_seq_ctrl: CYC_PER_MS must be positive");
   end
   if (VID_SETTLE_MS < 1) begin : g_bad_settle
      $error("pwr_seq_ctrl: VID settle time must be at least 1 ms");
   end
   if (VCC_TMO_MS < 1 || VCC_TMO_MS > 50) begin : g_bad_tmo
      $error("pwr_seq_ctrl: regulator timeout must lie in 1..50 ms");
   end
   if (RST_DLY_MS < 1 || RST_DLY_MS > 10) begin : g_bad_rst
      $error("pwr_seq_ctrl: reset delay must lie in 1..10 ms");
   end
   if (PG_LOW_TICKS < 1) begin : g_bad_ticks
      $error("pwr_seq_ctrl: PG_LOW_TICKS must be positive");
   end

   // input synchronization
   logic [SIG_CNT-1:0] raw_in, sync_out;
   logic vid_s, vcc_s, req_s;

   assign raw_in[SIG_VID] = vid_ok_a;
   assign raw_in[SIG_VCC] = vcc_ok_a;
   assign raw_in[SIG_REQ] = pwr_req_a;

   pwr_sync #(.WIDTH(SIG_CNT), .STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in),
      .dout (sync_out)
   );

   assign vid_s = sync_out[SIG_VID];
   assign vcc_s = sync_out[SIG_VCC];
   assign req_s = sync_out[SIG_REQ];

   // state and timers
   pseq_state_e state_q, state_d;
   logic          t_load, t_done, b_load, b_done;
   logic [TW-1:0] t_val;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:
            if (req_s && vid_s) state_d = ST_VID_WAIT;
         ST_VID_WAIT:
            if (!req_s || !vid_s) state_d = ST_IDLE;
            else if (t_done)      state_d = ST_VCC_WAIT;
         ST_VCC_WAIT:
            if (!vid_s)       state_d = ST_IDLE;
            else if (!req_s)  state_d = ST_OFF;
            else if (vcc_s)   state_d = ST_PG_HOLD;
            else if (t_done)  state_d = ST_FAULT;
         ST_PG_HOLD:
            if (!vid_s)                  state_d = ST_IDLE;
            else if (!req_s || !vcc_s)   state_d = ST_OFF;
            else if (bclk_tick && b_done) state_d = ST_RST_HOLD;
         ST_RST_HOLD:
            if (!vid_s)                state_d = ST_IDLE;
            else if (!req_s || !vcc_s) state_d = ST_OFF;
            else if (t_done)           state_d = ST_RUN;
         ST_RUN:
            if (!vid_s)                state_d = ST_IDLE;
            else if (!req_s || !vcc_s) state_d = ST_OFF;
         ST_OFF:
            state_d = ST_IDLE;
         ST_FAULT:
            if (!req_s) state_d = ST_IDLE;
         default:
            state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      unique case (state_d)
         ST_VID_WAIT: t_val = TW'(SETTLE_CYC - 1);
         ST_VCC_WAIT: t_val = TW'(TMO_CYC - 1);
         ST_RST_HOLD: t_val = TW'(RSTD_CYC - 1);
         default:     t_val = '0;
      endcase
   end

   assign t_load = (state_d != state_q);
   assign b_load = (state_d == ST_PG_HOLD) && (state_q != ST_PG_HOLD);

   pwr_tmr #(.W(TW)) i_ms_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (t_load),
      .load_val(t_val),
      .en      (1'b1),
      .done    (t_done)
   );

   pwr_tmr #(.W(BW)) i_tick_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (b_load),
      .load_val(BW'(PG_LOW_TICKS - 1)),
      .en      (bclk_tick),
      .done    (b_done)
   );

   // output decode, gated by the VID rail so a rail loss drops all at once
   always_comb begin
      vr_en     = 1'b0;
      pwr_good  = 1'b0;
      cpu_rst_n = 1'b0;
      unique case (state_q)
         ST_VCC_WAIT, ST_PG_HOLD, ST_OFF: vr_en = vid_s;
         ST_RST_HOLD: begin
            vr_en    = vid_s;
            pwr_good = vid_s;
         end
         ST_RUN: begin
            vr_en     = vid_s;
            pwr_good  = vid_s;
            cpu_rst_n = vid_s;
         end
         default: ;
      endcase
   end

   assign fault = (state_q == ST_FAULT);

endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk #(
   parameter int CYC_PER_MS    = 100000,
   parameter int VID_SETTLE_MS = 1
) (
   input logic clk,
   input logic rst_n,
   input logic vid_s,
   input logic req_s,
   input logic vr_en,
   input logic pwr_good,
   input logic cpu_rst_n,
   input logic fault
);

   localparam int unsigned SETTLE_CYC = VID_SETTLE_MS * CYC_PER_MS;
   localparam int unsigned RST_MIN    = CYC_PER_MS;
   localparam int unsigned RST_MAX    = 10 * CYC_PER_MS;

   int unsigned vid_hi_cnt;
   int unsigned pg_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vid_hi_cnt <= 0;
         pg_hi_cnt  <= 0;
      end else begin
         if (!vid_s)                    vid_hi_cnt <= 0;
         else if (vid_hi_cnt < SETTLE_CYC) vid_hi_cnt <= vid_hi_cnt + 1;
         if (!pwr_good)                 pg_hi_cnt <= 0;
         else if (pg_hi_cnt <= RST_MAX) pg_hi_cnt <= pg_hi_cnt + 1;
      end
   end

   AST_VR_OFF_NO_VID: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_s |-> !vr_en); // R1
   AST_VR_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vr_en) |-> vid_hi_cnt >= SETTLE_CYC); // R2
   AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!vr_en && !pwr_good && !cpu_rst_n)); // R4
   AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && req_s) |=> fault); // R5
   AST_RST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rst_n) |-> (pg_hi_cnt >= RST_MIN && pg_hi_cnt <= RST_MAX)); // R7
   AST_RST_NEEDS_PG: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |-> !cpu_rst_n); // R8
   AST_PG_BEFORE_VR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(vr_en) && vid_s) |-> !$past(pwr_good)); // R9

endmodule

bind pwr_seq_ctrl pwr_seq_chk #(
   .CYC_PER_MS   (CYC_PER_MS),
   .VID_SETTLE_MS(VID_SETTLE_MS)
) i_pwr_seq_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .vid_s    (vid_s),
   .req_s    (req_s),
   .vr_en    (vr_en),
   .pwr_good (pwr_good),
   .cpu_rst_n(cpu_rst_n),
   .fault    (fault)
);

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;

   localparam int CPM = 4;
   localparam int N1  = 1 * CPM;
   localparam int N2  = 50 * CPM;
   localparam int N3  = 2 * CPM;
   localparam int PGT = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk_tick = 1'b0;
   logic vid_ok_a = 1'b0;
   logic vcc_ok_a = 1'b0;
   logic pwr_req_a = 1'b0;
   logic vr_en, pwr_good, cpu_rst_n, fault;

   int errs = 0;
   int checks = 0;

   always #4 clk = ~clk;

   pwr_seq_ctrl #(
      .CYC_PER_MS(CPM), .VID_SETTLE_MS(1), .VCC_TMO_MS(50),
      .RST_DLY_MS(2), .PG_LOW_TICKS(PGT), .SYNC_STAGES(2)
   ) i_pwr_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick),
      .vid_ok_a(vid_ok_a), .vcc_ok_a(vcc_ok_a), .pwr_req_a(pwr_req_a),
      .vr_en(vr_en), .pwr_good(pwr_good), .cpu_rst_n(cpu_rst_n), .fault(fault)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic quiesce();
      vid_ok_a = 0; vcc_ok_a = 0; pwr_req_a = 0; bclk_tick = 0;
      repeat (8) step();
      chk("R10 idle outputs", int'({vr_en, pwr_good, cpu_rst_n, fault}), 0);
   endtask

   // d: edges after vr_en rise before valid; p/ph: tick period/phase; mode: power-down cause
   task automatic run_up(input int d, input int p, input int ph, input int mode);
      int n;
      int cnt;
      int exp_i;
      int obs_i;
      vid_ok_a = 1; pwr_req_a = 1; n = 0;
      while (!vr_en && n < 50) begin step(); n++; end
      chk("R2 enable delay", n, N1 + 3);
      repeat (d) step();
      vcc_ok_a = 1;
      if (d > N2 - 3) begin
         n = d;
         while (!fault && n < N2 + 50) begin step(); n++; end
         chk("R4 timeout edge", n, N2);
         chk("R4 enable low in fault", int'(vr_en), 0);
         repeat (10) step();
         chk("R5 fault held", int'(fault), 1);
         vcc_ok_a = 0; repeat (6) step();
         chk("R5 fault held after valid loss", int'(fault), 1);
         pwr_req_a = 0; step(); step();
         chk("R5 fault before sync", int'(fault), 1);
         step();
         chk("R5 fault cleared", int'(fault), 0);
      end else begin
         cnt = 0; exp_i = -1; obs_i = -1;
         for (int i = 1; i < 300 && (exp_i < 0 || obs_i < 0); i++) begin
            bclk_tick = ((i + ph) % p == 0);
            step();
            if (i >= 4 && bclk_tick) cnt++;
            if (cnt == PGT && exp_i < 0) exp_i = i;
            if (pwr_good && obs_i < 0) obs_i = i;
         end
         bclk_tick = 0;
         chk("R6 power-good edge", obs_i, exp_i);
         chk("R3 no fault on timely valid", int'(fault), 0);
         chk("R8 reset held at power-good rise", int'(cpu_rst_n), 0);
         n = 0;
         while (!cpu_rst_n && n < 100) begin step(); n++; end
         chk("R7 reset release delay", n, N3);
         if (mode == 2) begin
            vid_ok_a = 0;
            step();
            chk("R1 enable before sync", int'(vr_en), 1);
            step();
            chk("R1 all low on rail loss", int'({vr_en, pwr_good, cpu_rst_n}), 0);
         end else begin
            if (mode == 0) pwr_req_a = 0;
            else           vcc_ok_a = 0;
            step(); step();
            chk("R9 power-good before sync", int'(pwr_good), 1);
            step();
            chk("R9 step one", int'({vr_en, pwr_good, cpu_rst_n}), 3'b100);
            step();
            chk("R9 enable dropped", int'(vr_en), 0);
         end
      end
      quiesce();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) step();
      chk("R10 reset outputs", int'({vr_en, pwr_good, cpu_rst_n, fault}), 0);
      rst_n = 1;
      repeat (3) step();
      chk("R10 idle after reset", int'({vr_en, pwr_good, cpu_rst_n, fault}), 0);

      for (int p = 1; p <= 4; p++)
         for (int ph = 0; ph < p; ph++)
            run_up(0, p, ph, (p + ph) % 3);

      run_up(1, 2, 0, 0);
      run_up(57, 3, 1, 1);
      run_up(N2 - 3, 2, 1, 2);   // R3 last arrival that still succeeds
      run_up(N2 - 2, 1, 0, 0);   // R4 first arrival that faults
      run_up(N2 - 1, 1, 0, 0);

      // R11: request withdrawn during the settle interval
      vid_ok_a = 1; pwr_req_a = 1;
      repeat (3) step();
      pwr_req_a = 0;
      begin
         int seen = 0;
         for (int i = 0; i < 30; i++) begin
            step();
            if (vr_en) seen = 1;
         end
         chk("R11 enable never rises", seen, 0);
      end
      quiesce();

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule